// File: doc/BRIEF.md
# Operand and Target Address Resolver

This combinational unit takes one 32-bit instruction word in the classic three-format RISC encoding, the address of that instruction, and the two register values already read for its `rs` and `rt` fields. It sorts the instruction into one of five addressing modes. For that mode it produces the result the rest of the pipeline needs: the register indices, an extended immediate operand for the ALU, or a resolved byte address.

The address is formed in one of three ways. Loads and stores use the base register plus a signed byte displacement. Conditional branches use the following instruction's address plus a signed word offset. Jumps splice an absolute word index under the top bits of the following instruction's address. The unit also compares the two register values, so a branch's outcome is available in the same cycle as its target. It holds no state. The register file, memory and ALU sit outside it.

Top module: `ea_resolver`

## Requirements
- R1: `mode` encodes the addressing mode as follows: 0 is register (opcode 0x00), 1 is base plus displacement (0x23 load word, 0x2B store word), 2 is immediate (0x08 to 0x0F), 3 is PC-relative (0x04, 0x05), 4 is pseudo-direct (0x02, 0x03) and 7 is undefined (every other opcode). The opcode is `instr[31:26]`.
- R2: In register mode, `rs_idx`=`instr[25:21]`, `rt_idx`=`instr[20:16]`, `rd_idx`=`instr[15:11]` and `dst_idx`=`rd_idx`. `addr_valid` is 0 and `addr` is 0.
- R3: In base mode, `addr` = `rs_val` + sign-extended `instr[15:0]`, taken modulo 2^32. A zero displacement gives `rs_val` itself, and `addr_valid` is 1.
- R4: In immediate mode, `imm_op` is `instr[15:0]` sign-extended for opcodes 0x08 to 0x0B, zero-extended for 0x0C to 0x0E, and shifted left by 16 for 0x0F. In every other mode `imm_op` is 0.
- R5: In PC-relative mode, `addr` = `pc` + 4 + (sign-extended `instr[15:0]` << 2), so both forward and backward targets are reachable. `addr_valid` is 1.
- R6: In pseudo-direct mode, `addr` = {(`pc`+4)[31:28], `instr[25:0]`, 2'b00}, and `addr_valid` is 1.
- R7: `branch_taken` is 1 for opcode 0x04 when `rs_val`==`rt_val`, and for opcode 0x05 when they differ. For every other opcode it is 0.
- R8: `dst_idx` is `rt_idx` for immediate mode and for load word. It is 0 for store word, PC-relative, pseudo-direct and undefined.
- R9: In undefined mode, `addr_valid`, `addr`, `imm_op` and `branch_taken` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| pc | input | 32 | Byte address of the instruction |
| rs_val | input | 32 | Register value read for the rs field |
| rt_val | input | 32 | Register value read for the rt field |
| mode | output | 3 | Addressing mode code (R1) |
| rs_idx | output | 5 | rs register index |
| rt_idx | output | 5 | rt register index |
| rd_idx | output | 5 | rd register index |
| dst_idx | output | 5 | Register the instruction writes, 0 if none |
| imm_op | output | 32 | Extended immediate ALU operand |
| addr | output | 32 | Resolved memory or control-flow address |
| addr_valid | output | 1 | `addr` carries a resolved address |
| branch_taken | output | 1 | Conditional branch outcome |

## Verification
The bench builds the unit with its default parameters: logical immediates zero-extended and a branch offset scaled by four. With these settings the stimulus reaches the sign boundary of the 16-bit field (0x8000 and 0xFFFF), base-plus-displacement sums that wrap past 2^32, and backward branches. It also reaches a jump whose following-instruction address has just crossed into a new 256 MB region, where the region bits must come from `pc`+4 and not from `pc`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int INSN_W = 32;
  localparam int XLEN   = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  typedef enum logic [2:0] {
    MODE_REG    = 3'd0,
    MODE_BASE   = 3'd1,
    MODE_IMM    = 3'd2,
    MODE_PCREL  = 3'd3,
    MODE_PSEUDO = 3'd4,
    MODE_UNDEF  = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_kind_e;

  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0] OP_JLINK   = 6'h03;
  localparam logic [OPC_W-1:0] OP_BREQ    = 6'h04;
  localparam logic [OPC_W-1:0] OP_BRNE    = 6'h05;
  localparam logic [OPC_W-1:0] OP_LOADW   = 6'h23;
  localparam logic [OPC_W-1:0] OP_STOREW  = 6'h2B;
  localparam logic [OPC_W-1:0] OP_UPPER   = 6'h0F;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] upper_imm(input logic [IMM_W-1:0] v);
    return {v, {(XLEN-IMM_W){1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] next_pc(input logic [XLEN-1:0] p);
    return p + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] base_disp(input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] d);
    return b + d;
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] p,
                                                 input logic [XLEN-1:0] d,
                                                 input int unsigned sh);
    return next_pc(p) + (d << sh);
  endfunction

  function automatic logic [XLEN-1:0] abs_target(input logic [XLEN-1:0] p,
                                                 input logic [JIDX_W-1:0] idx);
    logic [XLEN-1:0] n;
    n = next_pc(p);
    return {n[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/ea_classify.sv
module ea_classify
  import ea_pkg::*;
#(
  parameter bit LOGIC_ZEXT = 1'b1
) (
  input  logic [OPC_W-1:0] opcode,
  output ea_mode_e         mode,
  output ext_kind_e        ext_kind,
  output logic             is_load,
  output logic             is_breq,
  output logic             is_brne
);
  always_comb begin
    mode     = MODE_UNDEF;
    ext_kind = EXT_SIGN;
    is_load  = 1'b0;
    is_breq  = 1'b0;
    is_brne  = 1'b0;
    unique case (opcode)
      OP_SPECIAL:          mode = MODE_REG;
      OP_JUMP, OP_JLINK:   mode = MODE_PSEUDO;
      OP_BREQ: begin
        mode    = MODE_PCREL;
        is_breq = 1'b1;
      end
      OP_BRNE: begin
        mode    = MODE_PCREL;
        is_brne = 1'b1;
      end
      OP_LOADW: begin
        mode    = MODE_BASE;
        is_load = 1'b1;
      end
      OP_STOREW:           mode = MODE_BASE;
      6'h08, 6'h09, 6'h0A, 6'h0B: mode = MODE_IMM;
      6'h0C, 6'h0D, 6'h0E: begin
        mode     = MODE_IMM;
        ext_kind = LOGIC_ZEXT ? EXT_ZERO : EXT_SIGN;
      end
      OP_UPPER: begin
        mode     = MODE_IMM;
        ext_kind = EXT_UPPER;
      end
      default:             mode = MODE_UNDEF;
    endcase
  end
endmodule

// File: rtl/ea_immext.sv
module ea_immext
  import ea_pkg::*;
(
  input  logic [IMM_W-1:0] imm_raw,
  input  ea_mode_e         mode,
  input  ext_kind_e        ext_kind,
  output logic [XLEN-1:0]  disp,
  output logic [XLEN-1:0]  imm_op
);
  logic [XLEN-1:0] alu_imm;

  assign disp = sext_imm(imm_raw);

  always_comb begin
    unique case (ext_kind)
      EXT_ZERO:  alu_imm = zext_imm(imm_raw);
      EXT_UPPER: alu_imm = upper_imm(imm_raw);
      default:   alu_imm = sext_imm(imm_raw);
    endcase
  end

  assign imm_op = (mode == MODE_IMM) ? alu_imm : '0;
endmodule

// File: rtl/ea_target.sv
module ea_target
  import ea_pkg::*;
#(
  parameter int unsigned BR_SHIFT = 2
) (
  input  ea_mode_e          mode,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   disp,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   addr,
  output logic              addr_valid
);
  always_comb begin
    addr       = '0;
    addr_valid = 1'b0;
    unique case (mode)
      MODE_BASE: begin
        addr       = base_disp(base, disp);
        addr_valid = 1'b1;
      end
      MODE_PCREL: begin
        addr       = rel_target(pc, disp, BR_SHIFT);
        addr_valid = 1'b1;
      end
      MODE_PSEUDO: begin
        addr       = abs_target(pc, jidx);
        addr_valid = 1'b1;
      end
      default: begin
        addr       = '0;
        addr_valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter bit          LOGIC_ZEXT = 1'b1,
  parameter int unsigned BR_SHIFT   = 2
) (
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [2:0]  mode,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [4:0]  rd_idx,
  output logic [4:0]  dst_idx,
  output logic [31:0] imm_op,
  output logic [31:0] addr,
  output logic        addr_valid,
  output logic        branch_taken
);
  localparam int RS_LSB = JIDX_W - RIDX_W;
  localparam int RT_LSB = RS_LSB - RIDX_W;
  localparam int RD_LSB = RT_LSB - RIDX_W;

  logic [OPC_W-1:0]  opcode;
  logic [IMM_W-1:0]  imm_raw;
  logic [JIDX_W-1:0] jidx;
  ea_mode_e          mode_w;
  ext_kind_e         ext_w;
  logic              is_load, is_breq, is_brne;
  logic [XLEN-1:0]   disp;
  logic              regs_equal;

  assign opcode  = instr[INSN_W-1 -: OPC_W];
  assign rs_idx  = instr[RS_LSB +: RIDX_W];
  assign rt_idx  = instr[RT_LSB +: RIDX_W];
  assign rd_idx  = instr[RD_LSB +: RIDX_W];
  assign imm_raw = instr[IMM_W-1:0];
  assign jidx    = instr[JIDX_W-1:0];

  ea_classify #(.LOGIC_ZEXT(LOGIC_ZEXT)) u_classify (
    .opcode   (opcode),
    .mode     (mode_w),
    .ext_kind (ext_w),
    .is_load  (is_load),
    .is_breq  (is_breq),
    .is_brne  (is_brne)
  );

  ea_immext u_immext (
    .imm_raw  (imm_raw),
    .mode     (mode_w),
    .ext_kind (ext_w),
    .disp     (disp),
    .imm_op   (imm_op)
  );

  ea_target #(.BR_SHIFT(BR_SHIFT)) u_target (
    .mode       (mode_w),
    .pc         (pc),
    .base       (rs_val),
    .disp       (disp),
    .jidx       (jidx),
    .addr       (addr),
    .addr_valid (addr_valid)
  );

  assign regs_equal   = (rs_val == rt_val);
  assign branch_taken = (is_breq & regs_equal) | (is_brne & ~regs_equal);
  assign mode         = mode_w;

  always_comb begin
    unique case (mode_w)
      MODE_REG:  dst_idx = rd_idx;
      MODE_IMM:  dst_idx = rt_idx;
      MODE_BASE: dst_idx = is_load ? rt_idx : '0;
      default:   dst_idx = '0;
    endcase
  end
endmodule

// File: rtl/ea_resolver_checker.sv
module ea_resolver_checker (
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [2:0]  mode,
  input logic [4:0]  rt_idx,
  input logic [4:0]  dst_idx,
  input logic [31:0] imm_op,
  input logic [31:0] addr,
  input logic        addr_valid,
  input logic        branch_taken
);
  logic [31:0] pc_next;
  assign pc_next = pc + 32'd4;

  always_comb begin
    a_r1_mode_legal: assert (mode <= 3'd4 || mode == 3'd7)
      else $error("mode code %0d outside the defined set", mode);
    a_r2_reg_no_addr: assert (mode != 3'd0 || (!addr_valid && addr == 32'd0))
      else $error("register mode produced an address");
    a_r5_rel_alignment: assert (mode != 3'd3 || addr[1:0] == pc[1:0])
      else $error("relative target lost pc alignment");
    a_r6_region_kept: assert (mode != 3'd4 ||
                              (addr[31:28] == pc_next[31:28] && addr[1:0] == 2'b00))
      else $error("absolute target left the region");
    a_r7_taken_is_branch: assert (!branch_taken || mode == 3'd3)
      else $error("taken flag outside branch mode");
    a_r4_imm_confined: assert (mode == 3'd2 || imm_op == 32'd0)
      else $error("immediate operand outside immediate mode");
    a_r8_no_dst_on_control: assert (!(mode == 3'd3 || mode == 3'd4 || mode == 3'd7) ||
                                    dst_idx == 5'd0)
      else $error("control transfer names a destination");
    a_r8_imm_dst: assert (mode != 3'd2 || dst_idx == rt_idx)
      else $error("immediate mode destination mismatch");
    a_r9_undef_quiet: assert (mode != 3'd7 || (!addr_valid && !branch_taken))
      else $error("undefined opcode produced a result, instr %h", instr);
  end
endmodule

bind ea_resolver ea_resolver_checker u_checker (
  .instr        (instr),
  .pc           (pc),
  .mode         (mode),
  .rt_idx       (rt_idx),
  .dst_idx      (dst_idx),
  .imm_op       (imm_op),
  .addr         (addr),
  .addr_valid   (addr_valid),
  .branch_taken (branch_taken)
);

// File: tb/ea_resolver_bench.sv
module ea_resolver_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 17;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] rsv;
    logic [31:0] rtv;
    logic [2:0]  mode;
    logic [31:0] addr;
    logic [31:0] imm;
    logic        valid;
    logic        taken;
    logic [4:0]  dst;
  } vec_t;

  // columns: instr, pc, rs_val, rt_val, mode, addr, imm_op, addr_valid, taken, dst
  localparam vec_t VEC [NVEC] = '{
    '{32'h012A4020, 32'h0, 32'h0, 32'h0, 3'd0, 32'h0, 32'h0, 1'b0, 1'b0, 5'd8},               // R2 add
    '{32'h8D280004, 32'h0, 32'h1000, 32'h0, 3'd1, 32'h1004, 32'h0, 1'b1, 1'b0, 5'd8},         // R3 lw +4
    '{32'h8D280000, 32'h0, 32'h2000, 32'h0, 3'd1, 32'h2000, 32'h0, 1'b1, 1'b0, 5'd8},         // R3 zero disp
    '{32'hAD28FFFC, 32'h0, 32'h1000, 32'h0, 3'd1, 32'h0FFC, 32'h0, 1'b1, 1'b0, 5'd0},         // R3 R8 sw -4
    '{32'h8D280008, 32'h0, 32'hFFFFFFFC, 32'h0, 3'd1, 32'h4, 32'h0, 1'b1, 1'b0, 5'd8},        // R3 wrap
    '{32'h2128FFFF, 32'h0, 32'h0, 32'h0, 3'd2, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 5'd8},        // R4 addi -1
    '{32'h3528FFFF, 32'h0, 32'h0, 32'h0, 3'd2, 32'h0, 32'h0000FFFF, 1'b0, 1'b0, 5'd8},        // R4 ori zext
    '{32'h3C081234, 32'h0, 32'h0, 32'h0, 3'd2, 32'h0, 32'h12340000, 1'b0, 1'b0, 5'd8},        // R4 upper
    '{32'h29288000, 32'h0, 32'h0, 32'h0, 3'd2, 32'h0, 32'hFFFF8000, 1'b0, 1'b0, 5'd8},        // R4 slti sext
    '{32'h31288000, 32'h0, 32'h0, 32'h0, 3'd2, 32'h0, 32'h00008000, 1'b0, 1'b0, 5'd8},        // R4 andi zext
    '{32'h112A0003, 32'h400, 32'h5, 32'h5, 3'd3, 32'h410, 32'h0, 1'b1, 1'b1, 5'd0},           // R5 R7 beq taken
    '{32'h112A0003, 32'h400, 32'h5, 32'h6, 3'd3, 32'h410, 32'h0, 1'b1, 1'b0, 5'd0},           // R7 beq not taken
    '{32'h152AFFFE, 32'h400, 32'h5, 32'h6, 3'd3, 32'h3FC, 32'h0, 1'b1, 1'b1, 5'd0},           // R5 bne backward
    '{32'h08100000, 32'h00400000, 32'h0, 32'h0, 3'd4, 32'h00400000, 32'h0, 1'b1, 1'b0, 5'd0}, // R6 j
    '{32'h0C000001, 32'hF0000000, 32'h0, 32'h0, 3'd4, 32'hF0000004, 32'h0, 1'b1, 1'b0, 5'd0}, // R6 jal top region
    '{32'h08000010, 32'h0FFFFFFC, 32'h0, 32'h0, 3'd4, 32'h10000040, 32'h0, 1'b1, 1'b0, 5'd0}, // R6 region cross
    '{32'hFC000000, 32'h0, 32'h7, 32'h7, 3'd7, 32'h0, 32'h0, 1'b0, 1'b0, 5'd0}                // R1 R9 undefined
  };

  logic        clk = 1'b0;
  logic [31:0] instr = '0, pc = '0, rs_val = '0, rt_val = '0;
  logic [2:0]  mode;
  logic [4:0]  rs_idx, rt_idx, rd_idx, dst_idx;
  logic [31:0] imm_op, addr;
  logic        addr_valid, branch_taken;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_resolver u_ea_resolver (
    .instr(instr), .pc(pc), .rs_val(rs_val), .rt_val(rt_val),
    .mode(mode), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
    .dst_idx(dst_idx), .imm_op(imm_op), .addr(addr),
    .addr_valid(addr_valid), .branch_taken(branch_taken)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; pc = p; rs_val = a; rt_val = b;
    #1;
  endtask

  initial begin
    // reset state: all-zero word is register mode on register 0
    apply(32'h0, 32'h0, 32'h0, 32'h0);
    check("R2", "idle mode", {29'd0, mode}, 32'd0);
    check("R2", "idle valid", {31'd0, addr_valid}, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k].instr, VEC[k].pc, VEC[k].rsv, VEC[k].rtv);
      check("R1", $sformatf("v%0d mode", k), {29'd0, mode}, {29'd0, VEC[k].mode});
      check("R3/R5/R6", $sformatf("v%0d addr", k), addr, VEC[k].addr);
      check("R4", $sformatf("v%0d imm", k), imm_op, VEC[k].imm);
      check("R9", $sformatf("v%0d valid", k), {31'd0, addr_valid}, {31'd0, VEC[k].valid});
      check("R7", $sformatf("v%0d taken", k), {31'd0, branch_taken}, {31'd0, VEC[k].taken});
      check("R8", $sformatf("v%0d dst", k), {27'd0, dst_idx}, {27'd0, VEC[k].dst});
    end

    // R2: field split of a register-format word
    apply(32'h03E0F82A, 32'h0, 32'h0, 32'h0);
    check("R2", "rs", {27'd0, rs_idx}, 32'd31);
    check("R2", "rt", {27'd0, rt_idx}, 32'd0);
    check("R2", "rd", {27'd0, rd_idx}, 32'd31);
    check("R2", "dst", {27'd0, dst_idx}, 32'd31);

    // R7: bne with equal registers does not take
    apply(32'h152AFFFE, 32'h400, 32'h9, 32'h9);
    check("R7", "bne equal", {31'd0, branch_taken}, 32'd0);

    // R5: most negative offset, pc 0x20000 -> 0x20004 - 0x20000 = 4
    apply(32'h11208000, 32'h20000, 32'h0, 32'h0);
    check("R5", "min offset", addr, 32'h00000004);

    // R9: another undefined opcode with nonzero fields
    apply(32'h9D28FFFF, 32'h400, 32'h1, 32'h1);
    check("R9", "undef mode", {29'd0, mode}, 32'd7);
    check("R9", "undef addr", addr, 32'd0);
    check("R9", "undef imm", imm_op, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule